// File: doc/BRIEF.md
# DMA Transfer Request Queue Controller

This block is the software-facing front end of a single-channel DMA engine. Software programs a set of transfer flags, then writes the start register. The block takes each accepted submission, gives it a hardware transfer ID from a rolling counter, and places it in a small in-order pending queue. A datapath consumer takes entries from the head of that queue with a request/acknowledge handshake. The consumer later reports each completion by ID.

The block raises two interrupt sources. The start-of-transfer source means a queue slot has been freed. The end-of-transfer source means a transfer has completed. Both sit in a pending register that software clears by writing ones, and a mask register decides which of them reach the interrupt line. Completions are also gathered in a done bitmask, with one bit per ID.

Registers use byte offsets on a 32-bit word port. Writes are synchronous, and reads are combinational from the current address. The offsets are: control 0x00, next-ID 0x04, start 0x08, flags 0x0C, interrupt mask 0x10, interrupt pending 0x14, and done mask 0x18.

Top module: `xferQueueCtrl`

## Requirements
- R1: After reset, the following read zero: control, next-ID, pending, done mask and start. The mask reads 3, which blocks both sources. `xferReq` and `irq` are low.
- R2: Control bit 0 is enable, bit 1 is pause and bit 2 is scatter-gather enable, and all three read back. `xferReq` is high only when enable is 1, pause is 0 and the queue holds at least one entry.
- R3: Writing the start register with bit 0 set, while enable is 1 and the queue is not full, queues one entry. That entry carries the ID shown in the next-ID register and the current flags. The next-ID then rises by one and wraps from IdCount-1 (default 30) back to 0.
- R4: The start register reads 1 while the queue holds QDepth entries, and reads 0 otherwise. A start write while the queue is full, or while enable is 0, queues nothing and leaves the next-ID unchanged.
- R5: `xferId` and `xferFlags` show the oldest queued entry. Each cycle with `xferReq` and `xferAck` both high removes that entry, so entries leave in submission order.
- R6: Writing the control register with bit 0 clear discards every queued entry. After that write, `xferReq` is low and the start register reads 0.
- R7: Pending bit 0 is set in the cycle after an entry is removed from the queue. Pending bit 1 is set in the cycle after a `xferDone` pulse.
- R8: Writing 1 to a pending bit clears it. If a new event for that bit arrives in the same cycle, the bit stays set.
- R9: `irq` is high when any pending bit is set whose mask bit (mask register bits 1:0) is 0. A mask bit of 1 blocks that source.
- R10: Done mask bit N is set after a completion for ID N. It is cleared when a new transfer with ID N is queued. Bit 31 always reads 0.
- R11: Flags bit 0 (cyclic), bit 1 (last of packet) and bit 2 (partial-length report) read back, and the upper bits read 0. The flags are carried on `xferFlags` with each queued entry.
- R12: Reads from any offset other than the seven mapped ones return 0. Writes to those offsets change no register. The next-ID, start-status and done registers ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | AddrW | Register byte offset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| xferReq | output | 1 | Head entry is available to the datapath |
| xferId | output | 5 | ID of the head entry |
| xferFlags | output | 3 | Flags of the head entry |
| xferAck | input | 1 | Datapath takes the head entry |
| xferDone | input | 1 | One transfer has completed |
| xferDoneId | input | 5 | ID of the completed transfer |
| irq | output | 1 | Interrupt line |

## Verification
The bench fills the queue while the channel is paused, so it can check the full indication. It then tries one more submission, because a controller that overflowed here would silently advance the ID and corrupt an older entry. It drives the ID counter through the wrap at 30 and then resubmits ID 0. A counter that ran to 31 would show up here, and so would a done mask that failed to clear a stale completion. It also lands a write-one-to-clear on the same cycle as a new start-of-transfer event, where a clear-wins design would lose an interrupt. Finally it disables the channel with entries still queued, where a design that kept them would keep requesting after a halt.

// File: rtl/dxqPkg.sv
package dxqPkg;
  localparam int IdW   = 5;
  localparam int FlagW = 3;

  localparam logic [7:0] OffCtrl   = 8'h00;
  localparam logic [7:0] OffNextId = 8'h04;
  localparam logic [7:0] OffStart  = 8'h08;
  localparam logic [7:0] OffFlags  = 8'h0C;
  localparam logic [7:0] OffMask   = 8'h10;
  localparam logic [7:0] OffPend   = 8'h14;
  localparam logic [7:0] OffDone   = 8'h18;

  // strobes from register control to the queue datapath
  typedef struct packed {
    logic             push;
    logic             flush;
    logic [FlagW-1:0] flags;
  } ctrlStrb_t;

  // status from the queue datapath back to register control
  typedef struct packed {
    logic           full;
    logic           pop;
    logic [IdW-1:0] nextId;
  } qStat_t;
endpackage

// File: rtl/dxqQueue.sv
module dxqQueue import dxqPkg::*; #(
  parameter int QDepth  = 4,
  parameter int IdCount = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic             runEn,
  input  logic             xferAck,
  input  logic             xferDone,
  input  logic [IdW-1:0]   xferDoneId,
  output qStat_t           qStat,
  output logic [31:0]      doneBits,
  output logic             xferReq,
  output logic [IdW-1:0]   xferId,
  output logic [FlagW-1:0] xferFlags
);
  localparam int PtrW = (QDepth > 1) ? $clog2(QDepth) : 1;
  localparam int CntW = $clog2(QDepth + 1);

  logic [IdW-1:0]   idMem [QDepth];
  logic [FlagW-1:0] flMem [QDepth];
  logic [PtrW-1:0]  wrPtr, rdPtr;
  logic [CntW-1:0]  count;
  logic [IdW-1:0]   nextId;
  logic             full, popEvt;

  assign full    = (count == CntW'(QDepth));
  assign xferReq = runEn && (count != '0);
  assign popEvt  = xferReq && xferAck;

  function automatic logic [PtrW-1:0] ptrInc(input logic [PtrW-1:0] p);
    return (p == PtrW'(QDepth - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      nextId <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) begin
        wrPtr  <= ptrInc(wrPtr);
        nextId <= (nextId == IdW'(IdCount - 1)) ? '0 : nextId + 1'b1;
      end
      if (popEvt) rdPtr <= ptrInc(rdPtr);
      count <= count + CntW'(strb.push) - CntW'(popEvt);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push && !strb.flush) begin
      idMem[wrPtr] <= nextId;
      flMem[wrPtr] <= strb.flags;
    end
  end

  for (genvar g = 0; g < IdCount; g++) begin : gDone
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        bitQ <= 1'b0;
      else if (xferDone && xferDoneId == IdW'(g))       bitQ <= 1'b1;
      else if (strb.push && nextId == IdW'(g))          bitQ <= 1'b0;
    end
    assign doneBits[g] = bitQ;
  end
  for (genvar g = IdCount; g < 32; g++) begin : gPad
    assign doneBits[g] = 1'b0;
  end

  assign xferId       = idMem[rdPtr];
  assign xferFlags    = flMem[rdPtr];
  assign qStat.full   = full;
  assign qStat.pop    = popEvt;
  assign qStat.nextId = nextId;

  // R4
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !full);
  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CntW'(QDepth));
  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> !xferReq);
  // R3
  id_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.flush) |=> (nextId != $past(nextId)));
  // R10
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && xferDoneId < IdW'(IdCount)) |=> doneBits[$past(xferDoneId)]);
endmodule

// File: rtl/dxqRegs.sv
module dxqRegs import dxqPkg::*; #(
  parameter int AddrW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] regAddr,
  input  logic             regWe,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  qStat_t           qStat,
  input  logic [31:0]      doneBits,
  input  logic             xferDone,
  output ctrlStrb_t        strb,
  output logic             runEn,
  output logic             irq
);
  logic [2:0]       ctrlQ;
  logic [FlagW-1:0] flagsQ;
  logic [1:0]       maskQ, pendQ;
  logic             wrCtrl, wrStart, wrFlags, wrMask, wrPend;
  logic             wdUnused;

  assign wdUnused = ^regWdata[31:3];

  assign wrCtrl  = regWe && (regAddr == AddrW'(OffCtrl));
  assign wrStart = regWe && (regAddr == AddrW'(OffStart));
  assign wrFlags = regWe && (regAddr == AddrW'(OffFlags));
  assign wrMask  = regWe && (regAddr == AddrW'(OffMask));
  assign wrPend  = regWe && (regAddr == AddrW'(OffPend));

  assign strb.push  = wrStart && regWdata[0] && ctrlQ[0] && !qStat.full;
  assign strb.flush = wrCtrl && !regWdata[0];
  assign strb.flags = flagsQ;
  assign runEn      = ctrlQ[0] && !ctrlQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      flagsQ <= '0;
      maskQ  <= 2'b11;
      pendQ  <= '0;
    end else begin
      if (wrCtrl)  ctrlQ  <= regWdata[2:0];
      if (wrFlags) flagsQ <= regWdata[FlagW-1:0];
      if (wrMask)  maskQ  <= regWdata[1:0];
      pendQ <= (pendQ & ~(wrPend ? regWdata[1:0] : 2'b00)) | {xferDone, qStat.pop};
    end
  end

  assign irq = |(pendQ & ~maskQ);

  always_comb begin
    regRdata = '0;
    if      (regAddr == AddrW'(OffCtrl))   regRdata = {29'b0, ctrlQ};
    else if (regAddr == AddrW'(OffNextId)) regRdata = {{(32-IdW){1'b0}}, qStat.nextId};
    else if (regAddr == AddrW'(OffStart))  regRdata = {31'b0, qStat.full};
    else if (regAddr == AddrW'(OffFlags))  regRdata = {{(32-FlagW){1'b0}}, flagsQ};
    else if (regAddr == AddrW'(OffMask))   regRdata = {30'b0, maskQ};
    else if (regAddr == AddrW'(OffPend))   regRdata = {30'b0, pendQ};
    else if (regAddr == AddrW'(OffDone))   regRdata = doneBits;
  end

  // R7
  sot_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    qStat.pop |=> pendQ[0]);
  // R7
  eot_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> pendQ[1]);
  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPend && regWdata[0] && !qStat.pop) |=> !pendQ[0]);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == 2'b11) |-> !irq);
endmodule

// File: rtl/xferQueueCtrl.sv
module xferQueueCtrl import dxqPkg::*; #(
  parameter int QDepth  = 4,
  parameter int IdCount = 31,
  parameter int AddrW   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] regAddr,
  input  logic             regWe,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output logic             xferReq,
  output logic [IdW-1:0]   xferId,
  output logic [FlagW-1:0] xferFlags,
  input  logic             xferAck,
  input  logic             xferDone,
  input  logic [IdW-1:0]   xferDoneId,
  output logic             irq
);
  ctrlStrb_t   strb;
  qStat_t      qStat;
  logic [31:0] doneBits;
  logic        runEn;

  dxqRegs #(.AddrW(AddrW)) uRegs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .qStat(qStat),
    .doneBits(doneBits), .xferDone(xferDone), .strb(strb),
    .runEn(runEn), .irq(irq)
  );

  dxqQueue #(.QDepth(QDepth), .IdCount(IdCount)) uQueue (
    .clk(clk), .rstN(rstN), .strb(strb), .runEn(runEn), .xferAck(xferAck),
    .xferDone(xferDone), .xferDoneId(xferDoneId), .qStat(qStat),
    .doneBits(doneBits), .xferReq(xferReq), .xferId(xferId),
    .xferFlags(xferFlags)
  );
endmodule

// File: tb/tb_xferQueueCtrl.sv
module tb_xferQueueCtrl;
  localparam int ClkPeriod = 10;
  localparam int NumVec = 10;
  // {addr[7:0], wdata[31:0], expected readback[31:0]}
  localparam logic [71:0] Vecs [NumVec] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h7},   // R2 all control bits
    {8'h00, 32'h0000_0002, 32'h2},   // R2 pause only
    {8'h0C, 32'hFFFF_FFFF, 32'h7},   // R11 flags upper bits dropped
    {8'h0C, 32'h0000_0005, 32'h5},   // R11
    {8'h10, 32'h0000_0001, 32'h1},   // R9 mask
    {8'h10, 32'hFFFF_FFFF, 32'h3},   // R9 mask
    {8'h1C, 32'hFFFF_FFFF, 32'h0},   // R12 unmapped
    {8'h40, 32'h1234_5678, 32'h0},   // R12 unmapped
    {8'h04, 32'h0000_001F, 32'h0},   // R12 next-ID read-only
    {8'h18, 32'h0000_FFFF, 32'h0}    // R12 done read-only
  };

  logic clk = 0, rstN = 0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 0;
  logic [31:0] regWdata = '0, regRdata;
  logic        xferReq, xferAck = 0, xferDone = 0, irq;
  logic [4:0]  xferId, xferDoneId = '0;
  logic [2:0]  xferFlags;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(ClkPeriod/2) clk = ~clk;

  xferQueueCtrl dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .xferReq(xferReq),
    .xferId(xferId), .xferFlags(xferFlags), .xferAck(xferAck),
    .xferDone(xferDone), .xferDoneId(xferDoneId), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic ack();
    @(negedge clk); xferAck = 1;
    @(negedge clk); xferAck = 0;
  endtask

  task automatic done(input logic [4:0] id);
    @(negedge clk); xferDone = 1; xferDoneId = id;
    @(negedge clk); xferDone = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(ClkPeriod * 100000);
    failures++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    finish();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h04, v); chk("R1 nextId", v, 0);
    rd(8'h08, v); chk("R1 start", v, 0);
    rd(8'h10, v); chk("R1 mask", v, 3);
    rd(8'h14, v); chk("R1 pend", v, 0);
    rd(8'h18, v); chk("R1 done", v, 0);
    chk("R1 xferReq/irq", {xferReq, irq}, 0);

    for (int i = 0; i < NumVec; i++) begin
      wr(Vecs[i][71:64], Vecs[i][63:32]);
      rd(Vecs[i][71:64], v);
      chk($sformatf("R2/R11/R12 vec%0d", i), v, Vecs[i][31:0]);
    end
    // state now: ctrl=2, flags=5, mask=3

    // R4 start ignored while disabled
    wr(8'h08, 1); rd(8'h04, v); chk("R4 disabled", v, 0);

    // fill queue while paused
    wr(8'h00, 3);
    wr(8'h08, 1);
    wr(8'h0C, 2);
    wr(8'h08, 1); wr(8'h08, 1); wr(8'h08, 1);
    rd(8'h08, v); chk("R4 full", v, 1);
    rd(8'h04, v); chk("R3 nextId", v, 4);
    chk("R2 paused", xferReq, 0);
    wr(8'h08, 1); rd(8'h04, v); chk("R4 full ignore", v, 4);

    // unpause
    wr(8'h00, 1); #1;
    chk("R2 running", xferReq, 1);
    chk("R5 head id", xferId, 0);
    chk("R11 head flags", xferFlags, 5);
    ack(); #1;
    chk("R5 next id", xferId, 1);
    chk("R5 next flags", xferFlags, 2);
    rd(8'h08, v); chk("R4 not full", v, 0);
    rd(8'h14, v); chk("R7 sot", v, 1);
    chk("R9 masked", irq, 0);
    wr(8'h10, 0); #1; chk("R9 unmasked", irq, 1);
    wr(8'h14, 1); rd(8'h14, v); chk("R8 w1c", v, 0);
    #1; chk("R9 irq clear", irq, 0);

    done(5'd0);
    rd(8'h18, v); chk("R10 done0", v, 32'h1);
    rd(8'h14, v); chk("R7 eot", v, 2);
    wr(8'h14, 2);

    // R6 flush
    wr(8'h00, 0); #1;
    chk("R6 req low", xferReq, 0);
    rd(8'h08, v); chk("R6 start", v, 0);
    wr(8'h00, 1); #1; chk("R6 empty", xferReq, 0);

    // R3 wrap
    for (int i = 4; i < 31; i++) begin
      wr(8'h08, 1); ack();
    end
    rd(8'h04, v); chk("R3 wrap", v, 0);
    wr(8'h08, 1);
    done(5'd30);
    rd(8'h18, v); chk("R10 reuse clear/bit31", v, 32'h4000_0000);
    #1; chk("R3 id0 reused", xferId, 0);

    // R8 set wins over clear
    wr(8'h14, 3);
    @(negedge clk); regAddr = 8'h14; regWdata = 1; regWe = 1; xferAck = 1;
    @(negedge clk); regWe = 0; xferAck = 0;
    rd(8'h14, v); chk("R8 set wins", v & 1, 1);

    finish();
  end
endmodule